// File: doc/BRIEF.md
# Table-Driven Finite State Machine

This block is a state machine whose whole behaviour is held in a writable lookup table instead of in fixed logic. On each clock, the current state and the external inputs together select one table word. That word carries both the next state and the output values. A single register captures the whole word, so the outputs are registered and move in the same cycle as the state.

A table of 2^(n+s) words of k+s bits gives the machine n inputs, k outputs and s state bits. The table is filled through a write port while a load-enable holds the machine still. Loading a different table changes the function without touching the logic. A synchronous reset returns the register to state zero with every output low. Reset leaves the table contents in place.

Top module: `table_fsm`

## Requirements
- R1: While `rst` is high at a rising clock edge, the register is cleared, so `stateOut` and `outBits` both read zero after that edge.
- R2: The lookup address is `{stateOut, inBits}`. The current state forms the upper ST_W bits and the inputs form the lower IN_W bits.
- R3: In each table word, bits [ST_W-1:0] are the next state and bits [OUT_W+ST_W-1:ST_W] are the outputs. Both are captured at the same edge, so `outBits` shows the outputs of the word looked up in the previous cycle.
- R4: When `loadEn` and `loadWe` are both high at a rising edge, `loadData` is stored at `loadAddr`. Every lookup after that edge sees the new word.
- R5: While `loadEn` is high and `rst` is low, `stateOut` and `outBits` hold their values.
- R6: When `loadEn` is low, `loadWe` has no effect and the table keeps its contents.
- R7: Loading a new table changes the behaviour of the machine without a reset. Reset does not clear the table.
- R8: Reset takes priority over `loadEn`. A reset during loading still clears the state and the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| loadEn | input | 1 | Freezes the machine and opens the table write port |
| loadWe | input | 1 | Table write strobe, honoured only with loadEn |
| loadAddr | input | IN_W+ST_W | Table write address |
| loadData | input | OUT_W+ST_W | Table write word: outputs in the upper bits, next state in the lower bits |
| inBits | input | IN_W | External inputs |
| outBits | output | OUT_W | Registered outputs |
| stateOut | output | ST_W | Current state |

## Verification
The state feeds back into the lookup address. A wrong state or a misplaced table word therefore shows up at `outBits` and `stateOut` one clock after the faulty lookup. It then usually throws the later trajectory off as well. A reference model in the bench follows the table and the state every cycle and compares both ports after each edge, so a fault is caught at the first cycle it becomes visible. Directed steps cover the corner cases: a write attempted with load disabled, a reset during loading, and reprogramming without reset. In each case the lookup that the fault would affect is made visible in the cycle that follows.

// File: rtl/tfsm_pkg.sv
package tfsm_pkg;

  // Strobes passed from control to datapath each cycle.
  typedef struct packed {
    logic clearReg;   // synchronous clear of state/output register
    logic captureEn;  // capture looked-up word into register
    logic writeEn;    // write one table word
  } tfsm_strobe_t;

endpackage

// File: rtl/tfsm_ctrl.sv
module tfsm_ctrl
  import tfsm_pkg::*;
(
  input  logic         rst,
  input  logic         loadEn,
  input  logic         loadWe,
  output tfsm_strobe_t strobes
);

  always_comb begin
    strobes           = '0;
    strobes.clearReg  = rst;
    // running only when neither reset nor loading
    strobes.captureEn = !rst && !loadEn;
    // writes gated by the load window
    strobes.writeEn   = loadEn && loadWe;
  end

endmodule

// File: rtl/tfsm_table.sv
module tfsm_table #(
  parameter int ADDR_W = 4,
  parameter int WORD_W = 5
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] wAddr,
  input  logic [WORD_W-1:0] wData,
  input  logic [ADDR_W-1:0] rAddr,
  output logic [WORD_W-1:0] rData
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] rowVal [DEPTH];

  for (genvar r = 0; r < DEPTH; r++) begin : gRow
    logic [WORD_W-1:0] word;
    logic              rowHit;

    assign rowHit = we && (wAddr == ADDR_W'(r));

    always_ff @(posedge clk) begin
      if (rowHit) word <= wData;
    end

    assign rowVal[r] = word;
  end

  assign rData = rowVal[rAddr];

endmodule

// File: rtl/tfsm_datapath.sv
module tfsm_datapath
  import tfsm_pkg::*;
#(
  parameter int IN_W  = 2,
  parameter int OUT_W = 3,
  parameter int ST_W  = 2
) (
  input  logic                  clk,
  input  tfsm_strobe_t          strobes,
  input  logic [ST_W+IN_W-1:0]  loadAddr,
  input  logic [OUT_W+ST_W-1:0] loadData,
  input  logic [IN_W-1:0]       inBits,
  output logic [OUT_W-1:0]      outBits,
  output logic [ST_W-1:0]       stateOut
);

  localparam int ADDR_W = ST_W + IN_W;
  localparam int WORD_W = OUT_W + ST_W;

  logic [WORD_W-1:0] regQ;
  logic [WORD_W-1:0] lookWord;
  logic [ADDR_W-1:0] lookAddr;

  // state in the upper address bits, inputs in the lower
  assign lookAddr = {regQ[ST_W-1:0], inBits};

  tfsm_table #(
    .ADDR_W(ADDR_W),
    .WORD_W(WORD_W)
  ) table_i (
    .clk  (clk),
    .we   (strobes.writeEn),
    .wAddr(loadAddr),
    .wData(loadData),
    .rAddr(lookAddr),
    .rData(lookWord)
  );

  // one register holds next state and outputs together
  always_ff @(posedge clk) begin
    if (strobes.clearReg)       regQ <= '0;
    else if (strobes.captureEn) regQ <= lookWord;
  end

  assign stateOut = regQ[ST_W-1:0];
  assign outBits  = regQ[WORD_W-1:ST_W];

endmodule

// File: rtl/table_fsm.sv
module table_fsm
  import tfsm_pkg::*;
#(
  parameter int IN_W  = 2,
  parameter int OUT_W = 3,
  parameter int ST_W  = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  loadEn,
  input  logic                  loadWe,
  input  logic [ST_W+IN_W-1:0]  loadAddr,
  input  logic [OUT_W+ST_W-1:0] loadData,
  input  logic [IN_W-1:0]       inBits,
  output logic [OUT_W-1:0]      outBits,
  output logic [ST_W-1:0]       stateOut
);

  tfsm_strobe_t strobes;

  tfsm_ctrl ctrl_i (
    .rst    (rst),
    .loadEn (loadEn),
    .loadWe (loadWe),
    .strobes(strobes)
  );

  tfsm_datapath #(
    .IN_W (IN_W),
    .OUT_W(OUT_W),
    .ST_W (ST_W)
  ) dp_i (
    .clk     (clk),
    .strobes (strobes),
    .loadAddr(loadAddr),
    .loadData(loadData),
    .inBits  (inBits),
    .outBits (outBits),
    .stateOut(stateOut)
  );

endmodule

// File: rtl/table_fsm_chk.sv
module table_fsm_chk #(
  parameter int IN_W  = 2,
  parameter int OUT_W = 3,
  parameter int ST_W  = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             loadEn,
  input logic [OUT_W-1:0] outBits,
  input logic [ST_W-1:0]  stateOut
);

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (stateOut == '0 && outBits == '0));

  assert_state_frozen_R5: assert property (@(posedge clk) disable iff (rst)
    loadEn |=> $stable(stateOut));

  assert_out_frozen_R5: assert property (@(posedge clk) disable iff (rst)
    loadEn |=> $stable(outBits));

  // any move of the register needs a reset or a running cycle before it (R8, R5)
  assert_move_needs_run_R8: assert property (@(posedge clk) disable iff (rst)
    !$stable({outBits, stateOut}) |-> ($past(rst) || !$past(loadEn)));

endmodule

bind table_fsm table_fsm_chk #(
  .IN_W (IN_W),
  .OUT_W(OUT_W),
  .ST_W (ST_W)
) chk_i (
  .clk     (clk),
  .rst     (rst),
  .loadEn  (loadEn),
  .outBits (outBits),
  .stateOut(stateOut)
);

// File: tb/tb_table_fsm.sv
`timescale 1ns/1ps
module tb_table_fsm;

  localparam int IN_W  = 2;
  localparam int OUT_W = 3;
  localparam int ST_W  = 2;
  localparam int AW    = IN_W + ST_W;
  localparam int WW    = OUT_W + ST_W;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          loadEn = 1'b0;
  logic          loadWe = 1'b0;
  logic [AW-1:0] loadAddr = '0;
  logic [WW-1:0] loadData = '0;
  logic [IN_W-1:0] inBits = '0;
  logic [OUT_W-1:0] outBits;
  logic [ST_W-1:0]  stateOut;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  // reference model
  logic [WW-1:0]    mTbl [DEPTH];
  logic [ST_W-1:0]  mSt = '0;
  logic [OUT_W-1:0] mOut = '0;

  always #4 clk = ~clk;

  table_fsm #(.IN_W(IN_W), .OUT_W(OUT_W), .ST_W(ST_W)) dut (
    .clk(clk), .rst(rst), .loadEn(loadEn), .loadWe(loadWe),
    .loadAddr(loadAddr), .loadData(loadData), .inBits(inBits),
    .outBits(outBits), .stateOut(stateOut)
  );

  function automatic logic [WW-1:0] progA(input int a);
    int st = a >> IN_W;
    int in = a & ((1 << IN_W) - 1);
    int nx = (st + in) % (1 << ST_W);
    int ou = (st * 3 + in) % (1 << OUT_W);
    return WW'((ou << ST_W) | nx);
  endfunction

  function automatic logic [WW-1:0] progB(input int a);
    int st = a >> IN_W;
    int in = a & ((1 << IN_W) - 1);
    int nx = st ^ in;
    int ou = 7 - ((st + in * 2) % 8);
    return WW'((ou << ST_W) | nx);
  endfunction

  task automatic finishRun();
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  // one cycle: drive at negedge, model at posedge, compare at next negedge
  task automatic step(input logic r, input logic le, input logic lw,
                      input logic [AW-1:0] a, input logic [WW-1:0] d,
                      input logic [IN_W-1:0] i, input string tag);
    logic [WW-1:0] w;
    rst = r; loadEn = le; loadWe = lw; loadAddr = a; loadData = d; inBits = i;
    @(posedge clk);
    if (r) begin
      mSt = '0; mOut = '0;
    end else if (!le) begin
      w = mTbl[{mSt, i}];
      mSt = w[ST_W-1:0];
      mOut = w[WW-1:ST_W];
    end
    if (le && lw) mTbl[a] = d;
    @(negedge clk);
    compared++;
    if ({outBits, stateOut} !== {mOut, mSt}) begin
      mismatched++;
      $display("FAIL %s: out=%0d state=%0d expected out=%0d state=%0d",
               tag, outBits, stateOut, mOut, mSt);
    end
  endtask

  task automatic loadTable(input bit useB, input string tag);
    for (int a = 0; a < DEPTH; a++)
      step(1'b0, 1'b1, 1'b1, AW'(a), useB ? progB(a) : progA(a), IN_W'(a * 3 + 1), tag);
  endtask

  task automatic runFor(input int n, input int seed, input string tag);
    for (int c = 0; c < n; c++)
      step(1'b0, 1'b0, 1'b0, '0, '0, IN_W'((c * seed + c / 3 + 1) % 4), tag);
  endtask

  initial begin
    for (int a = 0; a < DEPTH; a++) mTbl[a] = '0;
    @(negedge clk);
    // R1: reset state
    step(1'b1, 1'b0, 1'b0, '0, '0, '0, "R1");
    step(1'b1, 1'b0, 1'b0, '0, '0, 2'd3, "R1");
    // R4/R5: load table A while frozen
    loadTable(1'b0, "R5");
    // R2/R3: run under several input patterns
    runFor(24, 7, "R2");
    runFor(24, 5, "R3");
    // all-ones and all-zero input patterns
    for (int c = 0; c < 6; c++) step(1'b0, 1'b0, 1'b0, '0, '0, 2'd3, "R2");
    for (int c = 0; c < 4; c++) step(1'b0, 1'b0, 1'b0, '0, '0, 2'd0, "R3");
    // R6: write attempt with load disabled, then visit that address
    step(1'b1, 1'b0, 1'b0, '0, '0, '0, "R1");
    step(1'b0, 1'b0, 1'b1, AW'(1), '1, 2'd0, "R6");
    step(1'b0, 1'b0, 1'b0, '0, '0, 2'd1, "R6");
    step(1'b0, 1'b0, 1'b0, '0, '0, 2'd2, "R6");
    // R4: single-word rewrite during load, then exercise
    step(1'b0, 1'b1, 1'b1, AW'({2'd3, 2'd0}), WW'(5'b10110), 2'd1, "R4");
    runFor(16, 3, "R4");
    // R7: reprogram without reset
    loadTable(1'b1, "R7");
    runFor(30, 11, "R7");
    // R8: reset during loading
    step(1'b0, 1'b1, 1'b0, '0, '0, 2'd2, "R5");
    step(1'b1, 1'b1, 1'b0, '0, '0, 2'd2, "R8");
    step(1'b0, 1'b1, 1'b0, '0, '0, 2'd1, "R8");
    // R7: table survives reset
    runFor(20, 9, "R7");
    finishRun();
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: run not complete, expected completion");
      finishRun();
    end
  end

endmodule